// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives a processor core six 32-bit event counters. Counters one to four can each be pointed at an event through an 8-bit selector code. Counter five always counts retired instructions and counter six always counts clock cycles. Each cycle the core presents the number of instructions it retired in that cycle, along with a flag that shows whether it is in its run state. The counters add these values as their configuration and freeze controls allow.

Software sets up the unit through one write port and reads it back through a combinational read port. The write port reaches two control words and the six counters. The control word at address 6 holds three freeze bits, two overflow-enable bits and an exception-enable bit. The control word at address 7 holds the four event selectors. A counter that crosses into its top bit with overflow enabled is clamped at 0x80000000. That overflow raises a one-cycle exception request, but only when the exception enable is set.

Top module: `perf_mon_unit`

## Requirements
- R1: After a synchronous reset, all six counters and both control words read zero and `ovf_req` is low.
- R2: A write takes effect at the next clock edge. Addresses 0..5 select counters 1..6, address 6 selects control word A (bits 5:0) and address 7 selects control word B. `rd_data` shows the addressed register combinationally. A write to a counter replaces that cycle's increment of that counter and raises no overflow for it.
- R3: An overflow happens when a counter below 0x80000000 would reach 0x80000000 or more while its overflow enable is set. The counter is then loaded with exactly 0x80000000 and stays there while counting continues.
- R4: With its overflow enable clear, a counter adds past 0x80000000 without clamping and without raising a request.
- R5: Counter 1 uses enable bit 3 of control word A. Counters 2..6 share enable bit 4.
- R6: `ovf_req` is high for one cycle, in the cycle after the edge at which an overflow occurred. This happens only if bit 5 of control word A was set at that edge.
- R7: Bit 0 of control word A stops all six counters.
- R8: Bit 1 of control word A stops counters 1..4 only. Counters 1..4 are also idle while control word B is all zero.
- R9: Bit 2 of control word A stops counters 5 and 6. Otherwise counter 5 adds `ret_cnt` each cycle and counter 6 adds one.
- R10: Counter k (1..4) takes its 8-bit selector from control word B at bits [39-8k:32-8k], so counter 1 is in bits 31:24. Code 0x02 adds `ret_cnt`, code 0x1E adds one per cycle, and every other code leaves the counter idle.
- R11: Counter 4 also accepts code 0xFA, which adds `ret_cnt` only while `run_flag` is high. Code 0x02 on counter 4 counts whatever the state of `run_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_cnt | input | 3 | Instructions retired this cycle (0..4) |
| run_flag | input | 1 | Core run-state flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| cnt_vals | output | 192 | Counter values, counter k in bits [32k-1:32k-32] |
| ovf_req | output | 1 | Overflow exception request pulse |

## Verification
A software write to a counter and that same counter's overflow crossing can land on the same clock edge. The bench provokes this by letting counter 6 climb to 0x7FFFFFFF with overflow and exceptions enabled, then writing it in the very cycle it would cross. The check passes only if the written value appears, no clamp occurs and `ovf_req` stays low, and if the counter then resumes counting from the written value.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int CNT_W    = 32;
    localparam int NUM_CNT  = 6;
    localparam int NUM_PROG = 4;
    localparam int EVT_W    = 8;
    localparam int RET_W    = 3;
    localparam int ADDR_W   = 3;
    localparam int CTLA_W   = 6;
    localparam int CTLB_W   = NUM_PROG * EVT_W;

    localparam logic [ADDR_W-1:0] ADDR_CTLA = ADDR_W'(NUM_CNT);
    localparam logic [ADDR_W-1:0] ADDR_CTLB = ADDR_W'(NUM_CNT + 1);

    localparam logic [EVT_W-1:0] EV_INST     = 8'h02;
    localparam logic [EVT_W-1:0] EV_CYCLE    = 8'h1E;
    localparam logic [EVT_W-1:0] EV_INST_RUN = 8'hFA;

    // Control word A, bit 0 is the last field.
    typedef struct packed {
        logic exc_en;
        logic ovf_en_rest;
        logic ovf_en_first;
        logic frz_fixed;
        logic frz_prog;
        logic frz_all;
    } ctla_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_INST,
        SRC_INST_RUN,
        SRC_CYCLE
    } src_e;

    function automatic src_e decode_event(logic [EVT_W-1:0] code, logic run_capable);
        src_e s;
        if (code == EV_INST)
            s = SRC_INST;
        else if (code == EV_CYCLE)
            s = SRC_CYCLE;
        else if (run_capable && code == EV_INST_RUN)
            s = SRC_INST_RUN;
        else
            s = SRC_NONE;
        return s;
    endfunction

endpackage

// File: rtl/pmu_ctl_regs.sv
module pmu_ctl_regs
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctla_t             ctla_q,
    output logic [CTLB_W-1:0] ctlb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctla_q <= '0;
            ctlb_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTLA)
                ctla_q <= ctla_t'(wr_data[CTLA_W-1:0]);
            if (wr_addr == ADDR_CTLB)
                ctlb_q <= wr_data[CTLB_W-1:0];
        end
    end

endmodule

// File: rtl/pmu_src_sel.sv
module pmu_src_sel
    import pmu_pkg::*;
(
    input  ctla_t                           ctla,
    input  logic [CTLB_W-1:0]               ctlb,
    input  logic [RET_W-1:0]                ret_cnt,
    input  logic                            run_flag,
    output logic [NUM_CNT-1:0]              active,
    output logic [NUM_CNT-1:0][RET_W-1:0]   step,
    output logic [NUM_CNT-1:0]              ovf_en
);

    logic prog_gate;
    logic fixed_gate;

    assign prog_gate  = !ctla.frz_all && !ctla.frz_prog && (ctlb != '0);
    assign fixed_gate = !ctla.frz_all && !ctla.frz_fixed;

    genvar k;
    generate
        for (k = 0; k < NUM_PROG; k++) begin : g_prog
            src_e src;
            assign src = decode_event(ctlb[(NUM_PROG-1-k)*EVT_W +: EVT_W],
                                      k == NUM_PROG - 1);
            always_comb begin
                active[k] = 1'b0;
                step[k]   = '0;
                if (prog_gate) begin
                    unique case (src)
                        SRC_INST:     begin active[k] = 1'b1;     step[k] = ret_cnt;      end
                        SRC_INST_RUN: begin active[k] = run_flag; step[k] = ret_cnt;      end
                        SRC_CYCLE:    begin active[k] = 1'b1;     step[k] = RET_W'(1);    end
                        default:      begin active[k] = 1'b0;     step[k] = '0;           end
                    endcase
                end
            end
        end

        for (k = 0; k < NUM_CNT; k++) begin : g_en
            if (k == 0) begin : g_first
                assign ovf_en[k] = ctla.ovf_en_first;
            end else begin : g_rest
                assign ovf_en[k] = ctla.ovf_en_rest;
            end
        end
    endgenerate

    // Fixed-function counters: instructions then cycles.
    assign active[NUM_PROG]     = fixed_gate;
    assign step[NUM_PROG]       = ret_cnt;
    assign active[NUM_PROG + 1] = fixed_gate;
    assign step[NUM_PROG + 1]   = RET_W'(1);

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CW = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [IW-1:0] step,
    input  logic          ovf_en,
    input  logic          wr_hit,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] value,
    output logic          ovf_hit
);

    localparam logic [CW-1:0] LIMIT = {1'b1, {(CW-1){1'b0}}};

    logic [CW-1:0] sum;
    logic [CW-1:0] nxt;

    assign sum = value + CW'(step);

    always_comb begin
        nxt     = value;
        ovf_hit = 1'b0;
        if (wr_hit) begin
            nxt = wr_data;
        end else if (active && step != '0) begin
            if (ovf_en && value[CW-1]) begin
                nxt = value;
            end else if (ovf_en && sum[CW-1]) begin
                nxt     = LIMIT;
                ovf_hit = 1'b1;
            end else begin
                nxt = sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else
            value <= nxt;
    end

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [RET_W-1:0]         ret_cnt,
    input  logic                     run_flag,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [CNT_W-1:0]         rd_data,
    output logic [NUM_CNT*CNT_W-1:0] cnt_vals,
    output logic                     ovf_req
);

    ctla_t                          ctla_q;
    logic [CTLB_W-1:0]              ctlb_q;
    logic [CTLA_W-1:0]              ctla_vec;
    logic [NUM_CNT-1:0]             active;
    logic [NUM_CNT-1:0][RET_W-1:0]  step;
    logic [NUM_CNT-1:0]             ovf_en;
    logic [NUM_CNT-1:0]             ovf_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0]  value;

    assign ctla_vec = ctla_q;

    pmu_ctl_regs u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctla_q  (ctla_q),
        .ctlb_q  (ctlb_q)
    );

    pmu_src_sel u_sel (
        .ctla     (ctla_q),
        .ctlb     (ctlb_q),
        .ret_cnt  (ret_cnt),
        .run_flag (run_flag),
        .active   (active),
        .step     (step),
        .ovf_en   (ovf_en)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_cnt
            pmu_counter #(.CW(CNT_W), .IW(RET_W)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .active  (active[i]),
                .step    (step[i]),
                .ovf_en  (ovf_en[i]),
                .wr_hit  (wr_en && wr_addr == ADDR_W'(i)),
                .wr_data (wr_data),
                .value   (value[i]),
                .ovf_hit (ovf_hit[i])
            );
            assign cnt_vals[i*CNT_W +: CNT_W] = value[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ovf_req <= 1'b0;
        else
            ovf_req <= ctla_q.exc_en && (ovf_hit != '0);
    end

    always_comb begin
        if (rd_addr == ADDR_CTLA)
            rd_data = CNT_W'(ctla_vec);
        else if (rd_addr == ADDR_CTLB)
            rd_data = CNT_W'(ctlb_q);
        else
            rd_data = value[rd_addr];
    end

endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk
    import pmu_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [CTLA_W-1:0]        ctla_bits,
    input logic [NUM_CNT*CNT_W-1:0] cnt_vals,
    input logic                     ovf_req
);

    localparam logic [CNT_W-1:0] LIMIT = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cyc_cnt;
    logic [2*CNT_W-1:0] fixed_pair;
    logic any_at_limit;

    assign cyc_cnt    = cnt_vals[(NUM_CNT-1)*CNT_W +: CNT_W];
    assign fixed_pair = cnt_vals[(NUM_CNT-2)*CNT_W +: 2*CNT_W];

    always_comb begin
        any_at_limit = 1'b0;
        for (int j = 0; j < NUM_CNT; j++)
            if (cnt_vals[j*CNT_W +: CNT_W] == LIMIT)
                any_at_limit = 1'b1;
    end

    // R7: a global freeze with no write keeps every counter unchanged
    p_freeze_all_r7: assert property (@(posedge clk) disable iff (rst)
        (ctla_bits[0] && !wr_en) |=> $stable(cnt_vals));

    // R9: the fixed-group freeze keeps counters 5 and 6 unchanged
    p_freeze_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        (ctla_bits[2] && !wr_en) |=> $stable(fixed_pair));

    // R9: an unfrozen cycle counter advances by one per clock
    p_cycle_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctla_bits[0] && !ctla_bits[2] && !wr_en && !cyc_cnt[CNT_W-1])
        |=> cyc_cnt == $past(cyc_cnt) + 1'b1);

    // R6: the request only follows an edge at which the exception enable was set
    p_req_gated_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_req |-> $past(ctla_bits[5]));

    // R3: a request always coincides with a counter clamped at the limit
    p_req_clamped_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_req |-> any_at_limit);

endmodule

bind perf_mon_unit perf_mon_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .ctla_bits (ctla_vec),
    .cnt_vals  (cnt_vals),
    .ovf_req   (ovf_req)
);

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ret_cnt = '0;
    logic        run_flag = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [191:0] cnt_vals;
    logic        ovf_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    perf_mon_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .ret_cnt  (ret_cnt),
        .run_flag (run_flag),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cnt_vals (cnt_vals),
        .ovf_req  (ovf_req)
    );

    localparam logic [2:0] A_CTLA = 3'd6;
    localparam logic [2:0] A_CTLB = 3'd7;
    localparam logic [31:0] FRZ   = 32'h1;

    // {ctlA[5:0], ctlB[31:0], ret[2:0], run, per-cycle delta of counters 1..6}
    localparam int NV = 10;
    localparam logic [59:0] VEC [NV] = '{
        {6'h00, 32'h021E_0002, 3'd3, 1'b0, 3'd3, 3'd1, 3'd0, 3'd3, 3'd3, 3'd1},
        {6'h00, 32'h0000_00FA, 3'd2, 1'b1, 3'd0, 3'd0, 3'd0, 3'd2, 3'd2, 3'd1},
        {6'h00, 32'h0000_00FA, 3'd2, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd1},
        {6'h02, 32'h0202_0202, 3'd4, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd1},
        {6'h04, 32'h1E1E_1E1E, 3'd1, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0},
        {6'h01, 32'h0202_0202, 3'd2, 1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        {6'h00, 32'h0000_0000, 3'd4, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd1},
        {6'h00, 32'hFAFA_FA1E, 3'd1, 1'b1, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd1},
        {6'h00, 32'h0103_1FFB, 3'd4, 1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4, 3'd1},
        {6'h00, 32'h0202_0202, 3'd4, 1'b0, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd1}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic do_write(logic [2:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic freeze_and_clear();
        do_write(A_CTLA, FRZ);
        for (int c = 0; c < 6; c++) do_write(3'(c), 32'h0);
    endtask

    // Three-edge overflow scenario on one counter.
    task automatic ovf_case(string req, int idx, logic [31:0] ev, logic [31:0] init,
                            logic [5:0] ctla, logic [2:0] ret,
                            logic [31:0] exp_val, int exp_pulses);
        logic [31:0] v;
        int pulses = 0;
        freeze_and_clear();
        ret_cnt = ret; run_flag = 1'b0;
        do_write(3'(idx), init);
        do_write(A_CTLB, ev);
        do_write(A_CTLA, 32'(ctla));
        for (int e = 0; e < 3; e++) begin
            @(negedge clk);
            if (ovf_req) pulses++;
        end
        rd(3'(idx), v);
        check(req, v, exp_val);
        check(req, 32'(pulses), 32'(exp_pulses));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register and the request
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 reset ovf_req", 32'(ovf_req), 32'h0);

        // R2: control readback
        do_write(A_CTLA, 32'h0000_003F);
        rd(A_CTLA, v); check("R2 ctlA readback", v, 32'h3F);
        do_write(A_CTLB, 32'hA5C3_1E02);
        rd(A_CTLB, v); check("R2 ctlB readback", v, 32'hA5C3_1E02);

        // Vector table: R7 R8 R9 R10 R11
        for (int n = 0; n < NV; n++) begin
            logic [59:0] e;
            e = VEC[n];
            freeze_and_clear();
            do_write(A_CTLB, e[53:22]);
            ret_cnt  = e[21:19];
            run_flag = e[18];
            do_write(A_CTLA, 32'(e[59:54]));
            repeat (4) @(negedge clk);
            do_write(A_CTLA, FRZ);
            for (int c = 0; c < 6; c++) begin
                logic [31:0] exp;
                exp = 32'(e[17 - 3*c -: 3]) * 32'd5;
                rd(3'(c), v);
                if (v !== exp) begin
                    $display("  vector %0d counter %0d", n, c + 1);
                end
                check("R7/R8/R9/R10/R11 table", v, exp);
            end
        end

        // R3 R6: cycle counter 1 crosses with enable and exception
        ovf_case("R3/R6 c1 clamp+req", 0, 32'h1E00_0000, 32'h7FFF_FFFE, 6'h28, 3'd0, 32'h8000_0000, 1);
        // R6: clamp without exception enable raises no request
        ovf_case("R6 no exc", 0, 32'h1E00_0000, 32'h7FFF_FFFE, 6'h08, 3'd0, 32'h8000_0000, 0);
        // R4: enable clear, counter runs past the limit
        ovf_case("R4 no clamp", 0, 32'h1E00_0000, 32'h7FFF_FFFE, 6'h20, 3'd0, 32'h8000_0001, 0);
        // R5: counter 1 ignores the shared enable
        ovf_case("R5 c1 rest-en", 0, 32'h1E00_0000, 32'h7FFF_FFFE, 6'h30, 3'd0, 32'h8000_0001, 0);
        // R5: counter 2 follows the shared enable
        ovf_case("R5 c2 rest-en", 1, 32'h0002_0000, 32'h7FFF_FFFF, 6'h30, 3'd4, 32'h8000_0000, 1);
        ovf_case("R5 c2 first-en", 1, 32'h0002_0000, 32'h7FFF_FFFF, 6'h28, 3'd4, 32'h8000_000B, 0);
        // R3: exact landing on the limit by counter 5
        ovf_case("R3 c5 exact", 4, 32'h0000_0000, 32'h7FFF_FFF8, 6'h30, 3'd4, 32'h8000_0000, 1);
        // R3: counter 6 first edge crossing
        ovf_case("R3 c6 cross", 5, 32'h0000_0000, 32'h7FFF_FFFF, 6'h30, 3'd0, 32'h8000_0000, 1);

        // R2: write collides with counter 6 crossing
        freeze_and_clear();
        ret_cnt = 3'd0;
        do_write(3'd5, 32'h7FFF_FFFE);
        do_write(A_CTLA, 32'h30);
        @(negedge clk);
        rd(3'd5, v); check("R2 pre-collision", v, 32'h7FFF_FFFF);
        do_write(3'd5, 32'h5);
        rd(3'd5, v); check("R2 write wins", v, 32'h5);
        check("R2 no req on write", 32'(ovf_req), 32'h0);
        @(negedge clk);
        rd(3'd5, v); check("R2 resumes", v, 32'h6);
        check("R6 still quiet", 32'(ovf_req), 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule